// File: doc/BRIEF.md
# Nibble-Serial Phase Accumulator with Waveform Lookup

This block keeps a 12-bit phase for one axis. On each operating cycle it adds a signed 8-bit step to that phase. The addition runs one 4-bit digit at a time through a single shared 4-bit adder and a carry flip-flop. After the phase has settled, its upper eight bits address a sine table, and the table result drives an 8-bit DAC word.

A host loads the step through a narrow write port. An active-low strobe stores a 4-bit data nibble into one of four small registers, chosen by a 2-bit address. Register 0 holds the low nibble of the step. Register 1 holds the high nibble, and bit 3 of register 1 is the sign. A one-cycle start pulse runs three add subcycles and then one lookup cycle, which loads the output word and pulses a valid flag. A select input chooses whether the lookup returns sine or cosine.

Top module: `interp_phase_acc`

## Requirements
- R1: While `wr_ni` is low at a rising clock edge, `data_i` is stored into the register addressed by `addr_i`. Address 0 is the low step nibble and address 1 is the high step nibble.
- R2: While `rst_ni` is low, `acc_o` is 0, `dac_o` is 0x80, `valid_o` is 0, and all four step registers are 0.
- R3: One operating cycle replaces `acc_o` with (`acc_o` + S) mod 4096. S is the two's-complement value of the byte {register 1, register 0}, sign-extended to 12 bits.
- R4: The carry out of the low-nibble addition reaches the middle nibble, and the carry out of the middle nibble reaches the high nibble. For example, 0x0FF + 1 gives 0x100.
- R5: Negative steps and overflow wrap modulo 4096. The carry out of the high nibble is discarded. For example, 0x000 + (-128) gives 0xF80.
- R6: `acc_o` changes only during the three add subcycles of an operating cycle. Register writes and idle cycles leave it unchanged.
- R7: `start_i` is sampled high at a rising edge while the block is idle. The 4th rising edge after that edge sets `valid_o` for exactly one cycle, and `dac_o` is updated at that same edge.
- R8: With `sel_cos_i` low, `dac_o` becomes W(p). Here p = `acc_o`[11:4] and W(i) = 128 + floor(127·sin(2πi/256) + 0.5).
- R9: With `sel_cos_i` high during the lookup cycle, `dac_o` becomes W((p + 64) mod 256).
- R10: `start_i` is ignored while an operating cycle is in progress. Holding it high across a cycle produces exactly one addition and one valid pulse.
- R11: Writes to addresses 2 and 3 have no effect on the step that is added.
- R12: `dac_o` holds its value between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_ni | input | 1 | Active-low register write strobe |
| addr_i | input | 2 | Step register address |
| data_i | input | 4 | Nibble to write |
| start_i | input | 1 | Begin one accumulate-and-lookup cycle |
| sel_cos_i | input | 1 | 1 selects cosine, 0 selects sine |
| acc_o | output | 12 | Phase accumulator |
| dac_o | output | 8 | Offset-binary waveform sample |
| valid_o | output | 1 | One-cycle pulse when dac_o is updated |

## Verification
A carry that is mis-stored or not cleared shows up at `acc_o` on the same operating cycle, once the step crosses a nibble boundary. For this reason the stimulus walks the phase through 0x0FF and 0xFFF in both directions. A sequencer that miscounts subcycles moves or repeats the `valid_o` pulse, which the bench sees within five clocks of `start_i`. A start that is wrongly re-accepted produces a second addition, which the bench sees a few cycles after the first valid pulse. A wrong table index or a wrong cosine offset appears directly on `dac_o` at that pulse.

// File: rtl/interp_pkg.sv
package interp_pkg;
  localparam int NIB_W       = 4;
  localparam int ACC_NIBS    = 3;
  localparam int ACC_W       = NIB_W * ACC_NIBS;
  localparam int NUM_REGS    = 4;
  localparam int ADDR_W      = $clog2(NUM_REGS);
  localparam int CNT_W       = $clog2(ACC_NIBS);
  localparam int LUT_AW      = ACC_W - NIB_W;
  localparam int LUT_DEPTH   = 1 << LUT_AW;
  localparam int COS_OFS     = LUT_DEPTH / 4;
  localparam int OUT_W       = 2 * NIB_W;
  localparam int AMP         = (1 << (OUT_W - 1)) - 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADD  = 2'd1,
    ST_LOOK = 2'd2
  } seq_state_e;

  // offset-binary sine sample, evaluated at elaboration
  function automatic logic [OUT_W-1:0] wave_sample(input int idx);
    real ang;
    real val;
    ang = 2.0 * 3.14159265358979 * idx / LUT_DEPTH;
    val = AMP * $sin(ang);
    return OUT_W'((1 << (OUT_W - 1)) + $rtoi($floor(val + 0.5)));
  endfunction
endpackage

// File: rtl/interp_regfile.sv
module interp_regfile
  import interp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [NIB_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [NIB_W-1:0]  rd_data_o
);
  logic [NIB_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     regs_q[g] <= '0;
      else if (!wr_ni && wr_addr_i == ADDR_W'(g))      regs_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = regs_q[rd_addr_i];
endmodule

// File: rtl/interp_seq.sv
module interp_seq
  import interp_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  output logic [ACC_NIBS-1:0] nib_we_o,
  output logic [CNT_W-1:0]    nib_idx_o,
  output logic [ADDR_W-1:0]   rd_addr_o,
  output logic                sign_sel_o,
  output logic                load_o
);
  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACC_NIBS - 1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin state_d = ST_ADD; cnt_d = '0; end
      ST_ADD:  if (cnt_q == LAST) state_d = ST_LOOK;
               else cnt_d = cnt_q + 1'b1;
      ST_LOOK: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  for (genvar g = 0; g < ACC_NIBS; g++) begin : g_we
    assign nib_we_o[g] = (state_q == ST_ADD) && (cnt_q == CNT_W'(g));
  end

  assign nib_idx_o  = cnt_q;
  assign rd_addr_o  = (cnt_q == '0) ? ADDR_W'(0) : ADDR_W'(1);
  assign sign_sel_o = (cnt_q == LAST);
  assign load_o     = (state_q == ST_LOOK);

  // R3
  we_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(nib_we_o));
  // R10
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> !(nib_we_o[0] && $past(state_q) == ST_ADD));
  // R7
  load_after_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_we_o[ACC_NIBS-1] |=> load_o);
endmodule

// File: rtl/interp_datapath.sv
module interp_datapath
  import interp_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ACC_NIBS-1:0] nib_we_i,
  input  logic [CNT_W-1:0]    nib_idx_i,
  input  logic                sign_sel_i,
  input  logic [NIB_W-1:0]    step_nib_i,
  output logic [ACC_W-1:0]    acc_o
);
  logic [ACC_W-1:0] acc_q;
  logic             carry_q;
  logic [NIB_W-1:0] op_a, op_b;
  logic             cin;
  logic [NIB_W:0]   sum;

  assign op_a = sign_sel_i ? {NIB_W{step_nib_i[NIB_W-1]}} : step_nib_i;
  assign op_b = acc_q[nib_idx_i*NIB_W +: NIB_W];
  assign cin  = (nib_idx_i == '0) ? 1'b0 : carry_q;
  assign sum  = {1'b0, op_a} + {1'b0, op_b} + {{NIB_W{1'b0}}, cin};

  for (genvar g = 0; g < ACC_NIBS; g++) begin : g_nib
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          acc_q[g*NIB_W +: NIB_W] <= '0;
      else if (nib_we_i[g]) acc_q[g*NIB_W +: NIB_W] <= sum[NIB_W-1:0];
    end
  end

  // top-nibble carry dropped: modulo wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        carry_q <= 1'b0;
    else if (|nib_we_i) carry_q <= sign_sel_i ? 1'b0 : sum[NIB_W];
  end

  assign acc_o = acc_q;

  // R6
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|nib_we_i) |=> $stable(acc_q));
  // R4
  low_nib_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib_we_i[1] || nib_we_i[2]) |=> $stable(acc_q[NIB_W-1:0]));
endmodule

// File: rtl/interp_lut.sv
module interp_lut
  import interp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              sel_cos_i,
  input  logic [LUT_AW-1:0] phase_i,
  output logic [OUT_W-1:0]  dac_o,
  output logic              valid_o
);
  logic [NIB_W-1:0]  hi_tab [LUT_DEPTH];
  logic [NIB_W-1:0]  lo_tab [LUT_DEPTH];
  logic [LUT_AW-1:0] addr;
  logic [OUT_W-1:0]  dac_q;
  logic              valid_q;

  for (genvar g = 0; g < LUT_DEPTH; g++) begin : g_tab
    localparam logic [OUT_W-1:0] V = wave_sample(g);
    assign hi_tab[g] = V[OUT_W-1:NIB_W];
    assign lo_tab[g] = V[NIB_W-1:0];
  end

  assign addr = phase_i + (sel_cos_i ? LUT_AW'(COS_OFS) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_q   <= OUT_W'(1 << (OUT_W - 1));
      valid_q <= 1'b0;
    end else begin
      valid_q <= load_i;
      if (load_i) dac_q <= {hi_tab[addr], lo_tab[addr]};
    end
  end

  assign dac_o   = dac_q;
  assign valid_o = valid_q;

  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  // R12
  dac_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(dac_q));
endmodule

// File: rtl/interp_phase_acc.sv
module interp_phase_acc
  import interp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NIB_W-1:0]  data_i,
  input  logic              start_i,
  input  logic              sel_cos_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [OUT_W-1:0]  dac_o,
  output logic              valid_o
);
  logic [ACC_NIBS-1:0] nib_we;
  logic [CNT_W-1:0]    nib_idx;
  logic [ADDR_W-1:0]   rd_addr;
  logic [NIB_W-1:0]    rd_data;
  logic                sign_sel;
  logic                load;

  interp_regfile u_regs (
    .clk_i, .rst_ni, .wr_ni,
    .wr_addr_i (addr_i),
    .wr_data_i (data_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  interp_seq u_seq (
    .clk_i, .rst_ni, .start_i,
    .nib_we_o   (nib_we),
    .nib_idx_o  (nib_idx),
    .rd_addr_o  (rd_addr),
    .sign_sel_o (sign_sel),
    .load_o     (load)
  );

  interp_datapath u_dp (
    .clk_i, .rst_ni,
    .nib_we_i   (nib_we),
    .nib_idx_i  (nib_idx),
    .sign_sel_i (sign_sel),
    .step_nib_i (rd_data),
    .acc_o      (acc_o)
  );

  interp_lut u_lut (
    .clk_i, .rst_ni,
    .load_i    (load),
    .sel_cos_i (sel_cos_i),
    .phase_i   (acc_o[ACC_W-1:NIB_W]),
    .dac_o     (dac_o),
    .valid_o   (valid_o)
  );

  // R2
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (acc_o == '0 && !valid_o));
endmodule

// File: tb/interp_phase_acc_tb.sv
module interp_phase_acc_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_ni = 1'b1;
  logic [1:0] addr_i = '0;
  logic [3:0] data_i = '0;
  logic       start_i = 1'b0;
  logic       sel_cos_i = 1'b0;
  logic [11:0] acc_o;
  logic [7:0]  dac_o;
  logic        valid_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [11:0] m_acc = '0;
  logic [7:0]  m_step = '0;

  always #10 clk_i = ~clk_i;

  interp_phase_acc u_dut (.*);

  function automatic logic [7:0] ref_wave(input int idx);
    real v;
    v = 127.0 * $sin(2.0 * 3.14159265358979 * (idx % 256) / 256.0);
    return 8'(128 + $rtoi($floor(v + 0.5)));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk_i);
    wr_ni = 1'b0; addr_i = a; data_i = d;
    @(negedge clk_i);
    wr_ni = 1'b1;
  endtask

  task automatic set_step(input logic [7:0] s);
    write_reg(2'd0, s[3:0]);
    write_reg(2'd1, s[7:4]);
    m_step = s;
  endtask

  // hold = number of negedges start stays high
  task automatic accumulate(input logic cos, input int hold, input string req);
    int k;
    @(negedge clk_i);
    sel_cos_i = cos; start_i = 1'b1;
    k = 0;
    do begin
      @(negedge clk_i); k++;
      if (k >= hold) start_i = 1'b0;
    end while (!valid_o && k < 20);
    start_i = 1'b0;
    m_acc = m_acc + {{4{m_step[7]}}, m_step};
    check({req, " R7 latency"}, k, 5);
    check({req, " R3 acc"}, acc_o, m_acc);
    check({req, cos ? " R9 dac" : " R8 dac"},
          dac_o, ref_wave(int'(m_acc[11:4]) + (cos ? 64 : 0)));
    @(negedge clk_i);
    check({req, " R7 pulse width"}, valid_o, 1'b0);
  endtask

  task automatic t_reset();
    check("R2 acc", acc_o, 12'h000);
    check("R2 dac", dac_o, 8'h80);
    check("R2 valid", valid_o, 1'b0);
  endtask

  task automatic t_basic();
    set_step(8'h25);
    accumulate(1'b0, 1, "R1 basic");
  endtask

  task automatic t_carry();
    set_step(8'h7F); accumulate(1'b0, 1, "R4 step7F");
    set_step(8'h5B); accumulate(1'b1, 1, "R4 step5B");
    check("R4 at 0x0FF", acc_o, 12'h0FF);
    set_step(8'h01); accumulate(1'b0, 1, "R4 carry chain");
    check("R4 0x100", acc_o, 12'h100);
  endtask

  task automatic t_negative();
    set_step(8'h80);
    accumulate(1'b1, 1, "R5 neg1");
    accumulate(1'b0, 1, "R5 neg2");
    accumulate(1'b1, 1, "R5 neg3");
    check("R5 wrap below zero", acc_o, 12'hF80);
  endtask

  task automatic t_overflow();
    set_step(8'h7F);
    for (int i = 0; i < 36; i++) accumulate(i[0], 1, "R5 overflow sweep");
  endtask

  task automatic t_hold_start();
    logic [11:0] snap;
    logic [7:0]  dsnap;
    int pulses;
    set_step(8'h13);
    accumulate(1'b0, 3, "R10 held start");
    snap = acc_o; dsnap = dac_o; pulses = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (valid_o) pulses++;
    end
    check("R10 extra pulses", pulses, 0);
    check("R10 acc single add", acc_o, snap);
    check("R12 dac held", dac_o, dsnap);
  endtask

  task automatic t_idle_writes();
    logic [11:0] snap;
    snap = acc_o;
    write_reg(2'd2, 4'hF);
    write_reg(2'd3, 4'h9);
    write_reg(2'd0, 4'h6); m_step[3:0] = 4'h6;
    repeat (4) @(negedge clk_i);
    check("R6 acc stable on writes", acc_o, snap);
    accumulate(1'b0, 1, "R11 regs2/3 ignored");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_carry();
    t_negative();
    t_overflow();
    t_hold_start();
    t_idle_writes();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule